// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counter for generating an operating-system time base. Software programs a start value, selects whether counting follows the processor clock or a slower reference pulse, and enables the timer. Each time the count falls to zero, the timer latches a sticky flag and, if requested, issues a one-cycle exception request. On the count after reaching zero, it restarts from the programmed start value, so one period spans start value plus one counts.

Access is through a single-cycle 32-bit register port addressed by a 2-bit word index. Read data is combinational in the request cycle. Side effects of an access (write updates, flag clear on read) take place at the clock edge that ends the request cycle. The word index selects one of four registers: 0 control/status, 1 start value, 2 live count, 3 calibration.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, all four registers read zero, except calibration, and `tick_req_o` is low.
- R2: A write to control (index 0) updates only bit 0 (enable), bit 1 (request enable) and bit 2 (source: 1 = processor clock, 0 = reference pulse). Bits 31:17 and 15:3 read zero. A write never sets or clears the flag in bit 16.
- R3: With source 1 and enable set, the counter changes on every clock. When it is zero, it loads the start value. Otherwise it decrements. The period is therefore start value + 1 clocks.
- R4: With source 0 and enable set, the counter changes only in cycles where `ref_tick_i` is high.
- R5: The count that takes the counter from 1 to 0 sets the flag (bit 16). If request enable is set, the same count raises `tick_req_o` for exactly one cycle. The flag and the request become visible after the same edge.
- R6: A read of control returns the flag and then clears it. If the flag is set in the same cycle as the read, the set wins.
- R7: A write of any value to the live count (index 2) forces the counter to zero and clears the flag. The next count loads the start value without setting the flag or raising a request.
- R8: A count that finds the counter at zero while the start value is zero clears the enable bit, and counting stops.
- R9: While enable is clear, the live count reads zero and the counter holds its value. After enable is set again, counting resumes from the held value.
- R10: A control write that changes the source bit forces the counter to zero, so the next count loads the start value. A write that leaves the source bit unchanged does not disturb the counter.
- R11: The start value and live count are 24 bits wide and read back zero-extended. A write to the start value keeps its low 24 bits. Calibration (index 3) returns the parameter `CALIB_VAL`, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Synchronised single-cycle reference count pulse |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current request |
| tick_req_o | output | 1 | One-cycle exception request on reaching zero |

## Verification
The hardest case to reach is a control read whose clear lands on the exact edge where the counter falls to zero. The stimulus runs the counter from the processor clock with a known start value and counts edges from the enabling write, so the read strobe can be placed in the cycle just before expiry. Source switches, live-count writes and enable toggles are likewise placed at computed edges, with the counter holding a known mid-period value. Periods are swept over several small start values, on both the processor clock and a sparse reference-pulse pattern. At every edge, the expected count and request are computed from the edge index.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_CAL  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned IE_BIT   = 1;
  localparam int unsigned SRC_BIT  = 2;
  localparam int unsigned FLAG_BIT = 16;
endpackage

// File: rtl/systick_tick_sel.sv
module systick_tick_sel (
  input  logic en_i,
  input  logic src_i,
  input  logic ref_tick_i,
  output logic count_en_o
);
  // src_i = 1 counts every processor clock, 0 counts reference pulses
  assign count_en_o = en_i & (src_i | ref_tick_i);
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             zero_evt_o,
  output logic             stop_evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_q;
  logic             at_zero;
  logic             step;

  assign at_zero    = (cur_q == '0);
  assign step       = count_en_i & ~clr_i;
  assign zero_evt_o = step & (cur_q == ONE);
  assign stop_evt_o = step & at_zero & (reload_i == '0);
  assign cur_o      = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_q <= '0;
    else if (clr_i)    cur_q <= '0;
    else if (step) begin
      if (at_zero)     cur_q <= reload_i;
      else             cur_q <= cur_q - ONE;
    end
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && !clr_i && cur_q == '0) |=> cur_q == $past(reload_i));
  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && !clr_i && cur_q != '0) |=> cur_q == $past(cur_q) - ONE);
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cur_q == '0);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !clr_i) |=> $stable(cur_q));
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned  CNT_W     = 24,
  parameter logic [31:0]  CALIB_VAL = 32'h0000_03E8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              zero_evt_i,
  input  logic              stop_evt_i,
  output logic              en_o,
  output logic              src_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic              tick_req_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              flag_q;
  logic              tick_q;
  logic              wr_ctrl, rd_ctrl, wr_load, wr_cur, src_chg;
  reg_sel_e          sel;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(addr_i);
  assign wr_ctrl      = req_i &  we_i & (sel == SEL_CTRL);
  assign rd_ctrl      = req_i & ~we_i & (sel == SEL_CTRL);
  assign wr_load      = req_i &  we_i & (sel == SEL_LOAD);
  assign wr_cur       = req_i &  we_i & (sel == SEL_CUR);
  assign src_chg      = wr_ctrl & (wdata_i[SRC_BIT] != ctrl_q[SRC_BIT]);
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign clr_o      = wr_cur | src_chg;
  assign en_o       = ctrl_q[EN_BIT];
  assign src_o      = ctrl_q[SRC_BIT];
  assign reload_o   = reload_q;
  assign tick_req_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata_i[CTRL_W-1:0];
    end else if (stop_evt_i) begin
      ctrl_q[EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reload_q <= '0;
    else if (wr_load) reload_q <= wdata_i[CNT_W-1:0];
  end

  // set beats read-clear so an expiry is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (wr_cur)     flag_q <= 1'b0;
    else if (zero_evt_i) flag_q <= 1'b1;
    else if (rd_ctrl)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= zero_evt_i & ctrl_q[IE_BIT];
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata_o[CTRL_W-1:0] = ctrl_q;
        rdata_o[FLAG_BIT]   = flag_q;
      end
      SEL_LOAD: rdata_o = {{PAD_W{1'b0}}, reload_q};
      SEL_CUR:  rdata_o = ctrl_q[EN_BIT] ? {{PAD_W{1'b0}}, cur_i} : '0;
      SEL_CAL:  rdata_o = CALIB_VAL;
      default:  rdata_o = '0;
    endcase
  end

  p_tick_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  p_tick_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> flag_q);
  p_rdclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && !zero_evt_i && !wr_cur) |=> !flag_q);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_evt_i && !wr_cur) |=> flag_q);
  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt_i && !wr_ctrl) |=> !ctrl_q[EN_BIT]);
  p_wr_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter logic [31:0] CALIB_VAL = 32'h0000_03E8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_tick_i,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        tick_req_o
);
  logic             en, src, count_en, clr, zero_evt, stop_evt;
  logic [CNT_W-1:0] reload, cur;

  systick_regs #(.CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .cur_i      (cur),
    .zero_evt_i (zero_evt),
    .stop_evt_i (stop_evt),
    .en_o       (en),
    .src_o      (src),
    .reload_o   (reload),
    .clr_o      (clr),
    .tick_req_o (tick_req_o)
  );

  systick_tick_sel u_sel (
    .en_i       (en),
    .src_i      (src),
    .ref_tick_i (ref_tick_i),
    .count_en_o (count_en)
  );

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (count_en),
    .clr_i      (clr),
    .reload_i   (reload),
    .cur_o      (cur),
    .zero_evt_o (zero_evt),
    .stop_evt_o (stop_evt)
  );

  p_ref_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !src && !ref_tick_i && !clr) |=> $stable(cur));
endmodule

// File: tb/sys_tick_timer_bench.sv
module sys_tick_timer_bench;
  localparam logic [31:0] CAL = 32'h4000_0C35;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOAD = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  sys_tick_timer #(.CNT_W(24), .CALIB_VAL(CAL)) u_sys_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_req_o(tick)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    idle();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    idle();
    req = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic clean();
    wr(A_CTRL, 32'h0);
    wr(A_CUR, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    peek(A_LOAD, d); chk("R1 load", d, 32'h0);
    peek(A_CUR, d);  chk("R1 cur", d, 32'h0);
    chk("R1 tick", {31'b0, tick}, 32'h0);

    // R2 only bits 2:0 writable
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, d); chk("R2 upper ignored", d, 32'h0);
    wr(A_CTRL, 32'h0001_0006);
    rd(A_CTRL, d); chk("R2 flag not writable", d, 32'h6);

    // R11 widths and calibration
    clean();
    wr(A_LOAD, 32'hFFFF_FFFF);
    peek(A_LOAD, d); chk("R11 load zero-extended", d, 32'h00FF_FFFF);
    peek(A_CAL, d);  chk("R11 calib", d, CAL);
    wr(A_CAL, 32'h0);
    peek(A_CAL, d);  chk("R11 calib write ignored", d, CAL);
    wr(A_CTRL, 32'h5);
    idle();
    peek(A_CUR, d);  chk("R11 cur zero-extended", d, 32'h00FF_FFFF);
    idle();
    peek(A_CUR, d);  chk("R11 cur decrement", d, 32'h00FF_FFFE);

    // R3 R5 processor clock sweep
    for (int r = 1; r <= 5; r++) begin
      clean();
      wr(A_LOAD, r);
      wr(A_CTRL, 32'h7);
      for (int k = 1; k <= 3 * (r + 1); k++) begin
        int m;
        idle();
        m = (k - 1) % (r + 1);
        peek(A_CUR, d); chk("R3 count", d, r - m);
        chk("R5 tick pulse", {31'b0, tick}, (m == r) ? 32'h1 : 32'h0);
      end
    end

    // R4 reference pulses every third cycle
    clean();
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, 32'h3);
    n = 0;
    for (int k = 1; k <= 30; k++) begin
      logic p;
      logic [31:0] ec, et;
      p = (k % 3 == 0);
      ref_tick = p;
      idle();
      ref_tick = 1'b0;
      if (p) n++;
      ec = (n == 0) ? 32'd0 : 32'(3 - (n - 1) % 4);
      et = (p && n > 0 && (n - 1) % 4 == 3) ? 32'h1 : 32'h0;
      peek(A_CUR, d); chk("R4 ref count", d, ec);
      chk("R4 ref tick", {31'b0, tick}, et);
    end

    // R5 no request when request enable clear; R2 flag survives ctrl write
    clean();
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h5);
    for (int k = 1; k <= 3; k++) begin
      idle();
      chk("R5 no tick when disabled", {31'b0, tick}, 32'h0);
    end
    wr(A_CTRL, 32'h4);
    rd(A_CTRL, d); chk("R5 R2 flag kept", d, 32'h0001_0004);
    rd(A_CTRL, d); chk("R6 read clears", d, 32'h4);

    // R6 set wins over read-clear on the same edge
    clean();
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, 32'h5);
    idle(); idle(); idle();
    rd(A_CTRL, d); chk("R6 before expiry", d, 32'h5);
    rd(A_CTRL, d); chk("R6 set wins", d, 32'h0001_0005);
    rd(A_CTRL, d); chk("R6 cleared", d, 32'h5);

    // R7 write to live count
    clean();
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h7);
    idle(); idle(); idle(); idle();
    wr(A_CUR, 32'h00AB_CDEF);
    peek(A_CUR, d); chk("R7 cleared count", d, 32'h0);
    idle();
    chk("R7 no tick on reload", {31'b0, tick}, 32'h0);
    peek(A_CUR, d); chk("R7 reload next count", d, 32'h2);
    rd(A_CTRL, d); chk("R7 flag cleared", d, 32'h7);

    // R8 zero reload stops the timer
    clean();
    wr(A_LOAD, 32'h0);
    wr(A_CTRL, 32'h7);
    idle();
    rd(A_CTRL, d); chk("R8 stop at once", d, 32'h6);
    chk("R8 no tick", {31'b0, tick}, 32'h0);
    clean();
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'h5);
    wr(A_LOAD, 32'h0);
    idle(); idle();
    rd(A_CTRL, d); chk("R8 stop after expiry", d, 32'h0001_0004);

    // R9 disable freezes and hides count
    clean();
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'h5);
    idle(); idle();
    wr(A_CTRL, 32'h4);
    peek(A_CUR, d); chk("R9 reads zero disabled", d, 32'h0);
    idle(); idle();
    peek(A_CUR, d); chk("R9 still zero", d, 32'h0);
    wr(A_CTRL, 32'h5);
    peek(A_CUR, d); chk("R9 held value", d, 32'h3);
    idle();
    peek(A_CUR, d); chk("R9 resumes", d, 32'h2);

    // R10 source change forces reload
    clean();
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'h5);
    idle(); idle();
    wr(A_CTRL, 32'h1);
    peek(A_CUR, d); chk("R10 cleared on switch", d, 32'h0);
    ref_tick = 1'b1; idle(); ref_tick = 1'b0;
    peek(A_CUR, d); chk("R10 reload", d, 32'h5);
    idle();
    peek(A_CUR, d); chk("R10 waits for pulse", d, 32'h5);
    ref_tick = 1'b1; idle(); ref_tick = 1'b0;
    peek(A_CUR, d); chk("R10 decrement", d, 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule